// File: doc/BRIEF.md
# Descriptor Ring Copy Engine (single queue pair)

This block is the engine behind one channel of a descriptor-driven memory-copy DMA. Software places 32-byte work entries in a circular submission ring in memory and then writes a new tail index. The engine walks the ring from its own head index up to that tail. For each entry it fetches the entry, decodes it and, when the entry asks for a copy, moves the data one 64-bit word at a time. It then posts a 16-byte completion record into a second circular ring and, if the entry requested it, pulses an interrupt.

Both ring bases and the ring depth (written as depth minus one) are inputs. Software frees completion records by writing the completion head index. The engine never overwrites a record that software has not yet released. A queue reset puts all ring indices back to zero. Every memory access goes through one abstract 64-bit port: the engine raises a request and holds it unchanged until the memory acknowledges it, and read data is taken in the acknowledge cycle.

Top module: `qp_engine`

## Requirements
- R1: After reset, `irq` and `mem_req` are low, and `sq_head` and `cq_tail` are zero.
- R2: An entry at index i is read as four 64-bit words at `sq_base + 32*i + 0/8/16/24`. Word 0 bits 3:0 are the opcode and bit 8 is the interrupt request. Word 1 bits 63:32 are the byte length. Word 2 is the source address and word 3 is the destination address.
- R3: Opcode 4 copies ceil(length/8) 64-bit words from source to destination, in ascending address order, and writes nothing beyond them. A length of zero moves nothing and still completes.
- R4: Any opcode other than 4 moves no data and completes with status 1. Opcode 4 completes with status 0.
- R5: The completion record for the k-th processed entry goes to `cq_base + 16*cq_tail`. Its first word is zero. Its second word carries the updated submission head in bits 15:0, a valid bit of 1 in bit 48, and the status in bits 63:49.
- R6: A write on `sq_tail_wr` starts processing. Entries are consumed from `sq_head` up to, but not including, the written tail, and `sq_head` advances once each entry has been fetched.
- R7: Both `sq_head` and `cq_tail` return to zero after reaching `depth_m1`.
- R8: No completion record is written while the successor of `cq_tail` equals the completion head. The engine waits there until a `cq_head_wr` frees space.
- R9: When the entry's bit 8 is set, `irq` is high for exactly one cycle, in the cycle after the acknowledge of the last completion-record write. Otherwise it stays low.
- R10: `q_reset` zeroes the submission tail, `sq_head`, the completion head and `cq_tail`, and abandons any work in progress.
- R11: While `mem_req` is high and `mem_ack` is low, the request, address, direction and write data hold unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_reset | input | 1 | Queue reset pulse, zeroes all ring indices |
| depth_m1 | input | PW | Ring depth minus one (both rings) |
| sq_base | input | AW | Submission ring byte base |
| cq_base | input | AW | Completion ring byte base |
| sq_tail_wr | input | 1 | Submission tail doorbell strobe |
| sq_tail_val | input | PW | New submission tail index |
| cq_head_wr | input | 1 | Completion head update strobe |
| cq_head_val | input | PW | New completion head index |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address (8-byte aligned) |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 64 | Read data |
| irq | output | 1 | Completion interrupt pulse |
| sq_head | output | PW | Engine's submission head index |
| cq_tail | output | PW | Next completion record index |

## Verification
The hardest state to reach is the stall on a full completion ring while more work is still queued. The submission ring can hold at most depth-1 pending entries, so filling the completion ring takes two rounds. The stimulus first completes two entries without releasing their records, then queues two more. The engine posts one record and must then sit, with the next entry already fetched and copied, until a completion-head write releases space. Ring wrap is reached by running more table entries than the four-deep rings hold. The memory model withholds acknowledges on a repeating pattern, so requests must hold across wait cycles.

// File: rtl/qp_engine.sv
module qp_engine #(
  parameter int AW = 64,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_reset,
  input  logic [PW-1:0] depth_m1,
  input  logic [AW-1:0] sq_base,
  input  logic [AW-1:0] cq_base,
  input  logic          sq_tail_wr,
  input  logic [PW-1:0] sq_tail_val,
  input  logic          cq_head_wr,
  input  logic [PW-1:0] cq_head_val,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata,
  output logic          irq,
  output logic [PW-1:0] sq_head,
  output logic [PW-1:0] cq_tail
);

  localparam logic [3:0]  OP_COPY = 4'h4;
  localparam logic [14:0] ST_BADOP = 15'd1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_CQCHK, S_CQWR} st_t;

  st_t           state;
  logic [1:0]    beat;
  logic [3:0]    op_q;
  logic          ien_q;
  logic [31:0]   len_q;
  logic [AW-1:0] src_q, dst_q;
  logic [29:0]   words_left;
  logic [31:0]   off;
  logic [63:0]   rbuf;
  logic [PW-1:0] sq_tail, cq_head;

  logic [PW-1:0] sq_nxt, cq_nxt;
  logic          acc, bad_op;
  logic [29:0]   nwords;
  logic [14:0]   status;
  logic [63:0]   cq_word;

  assign sq_nxt  = (sq_head == depth_m1) ? '0 : sq_head + 1'b1;
  assign cq_nxt  = (cq_tail == depth_m1) ? '0 : cq_tail + 1'b1;
  assign acc     = mem_req && mem_ack;
  assign bad_op  = (op_q != OP_COPY);
  assign status  = bad_op ? ST_BADOP : 15'd0;
  assign nwords  = {1'b0, len_q[31:3]} + {29'd0, |len_q[2:0]};
  assign cq_word = {status, 1'b1, 32'd0, {(16-PW){1'b0}}, sq_head};

  assign mem_req = (state == S_FETCH) || (state == S_RD) || (state == S_WR) || (state == S_CQWR);
  assign mem_we  = (state == S_WR) || (state == S_CQWR);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_FETCH: mem_addr = sq_base + {{(AW-PW-5){1'b0}}, sq_head, 5'b0}
                                  + {{(AW-5){1'b0}}, beat, 3'b0};
      S_RD:    mem_addr = src_q + {{(AW-32){1'b0}}, off};
      S_WR: begin
        mem_addr  = dst_q + {{(AW-32){1'b0}}, off};
        mem_wdata = rbuf;
      end
      S_CQWR: begin
        mem_addr  = cq_base + {{(AW-PW-4){1'b0}}, cq_tail, 4'b0}
                            + {{(AW-4){1'b0}}, beat[0], 3'b0};
        mem_wdata = beat[0] ? cq_word : 64'd0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      beat       <= '0;
      op_q       <= '0;
      ien_q      <= 1'b0;
      len_q      <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      words_left <= '0;
      off        <= '0;
      rbuf       <= '0;
      sq_head    <= '0;
      sq_tail    <= '0;
      cq_head    <= '0;
      cq_tail    <= '0;
      irq        <= 1'b0;
    end else if (q_reset) begin
      state   <= S_IDLE;
      beat    <= '0;
      sq_head <= '0;
      sq_tail <= '0;
      cq_head <= '0;
      cq_tail <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (sq_tail_wr) sq_tail <= sq_tail_val;
      if (cq_head_wr) cq_head <= cq_head_val;
      case (state)
        S_IDLE:
          if (sq_head != sq_tail) begin
            state <= S_FETCH;
            beat  <= '0;
          end
        S_FETCH:
          if (acc) begin
            beat <= beat + 1'b1;
            case (beat)
              2'd0: begin
                op_q  <= mem_rdata[3:0];
                ien_q <= mem_rdata[8];
              end
              2'd1: len_q <= mem_rdata[63:32];
              2'd2: src_q <= mem_rdata[AW-1:0];
              default: begin
                dst_q      <= mem_rdata[AW-1:0];
                sq_head    <= sq_nxt;
                words_left <= nwords;
                off        <= '0;
                state      <= (!bad_op && nwords != 0) ? S_RD : S_CQCHK;
              end
            endcase
          end
        S_RD:
          if (acc) begin
            rbuf  <= mem_rdata;
            state <= S_WR;
          end
        S_WR:
          if (acc) begin
            off        <= off + 32'd8;
            words_left <= words_left - 1'b1;
            state      <= (words_left == 30'd1) ? S_CQCHK : S_RD;
          end
        S_CQCHK:
          if (cq_nxt != cq_head) begin
            state <= S_CQWR;
            beat  <= '0;
          end
        S_CQWR:
          if (acc) begin
            beat <= beat + 1'b1;
            if (beat[0]) begin
              cq_tail <= cq_nxt;
              irq     <= ien_q;
              state   <= S_IDLE;
            end
          end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qp_engine_chk.sv
module qp_engine_chk #(
  parameter int AW = 64,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          q_reset,
  input logic [PW-1:0] depth_m1,
  input logic          cq_head_wr,
  input logic [PW-1:0] cq_head,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [63:0]   mem_wdata,
  input logic          mem_ack,
  input logic          irq,
  input logic [PW-1:0] sq_head,
  input logic [PW-1:0] cq_tail
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || q_reset)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  irq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req && mem_ack && mem_we));

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_head <= depth_m1) && (cq_tail <= depth_m1));

  // R8
  cq_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(cq_tail) && !$past(q_reset) && !$past(cq_head_wr)) |-> (cq_tail != cq_head));

  // R10
  qreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_reset |=> (sq_head == '0 && cq_tail == '0 && !mem_req));

endmodule

bind qp_engine qp_engine_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_reset(q_reset), .depth_m1(depth_m1),
  .cq_head_wr(cq_head_wr), .cq_head(cq_head), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq(irq),
  .sq_head(sq_head), .cq_tail(cq_tail)
);

// File: tb/qp_engine_tb.sv
module qp_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int PW = 16;
  localparam int NV = 6;
  localparam int CQW = 32;   // word index of cq_base (0x100)
  localparam int SRCW = 128; // 0x400
  localparam int DSTW = 256; // 0x800

  // {opcode, irq_en, length, expected status}
  localparam logic [51:0] VEC [NV] = '{
    {4'h4, 1'b1, 32'd16, 15'd0},
    {4'h4, 1'b0, 32'd20, 15'd0},
    {4'h1, 1'b1, 32'd24, 15'd1},
    {4'h4, 1'b1, 32'd0,  15'd0},
    {4'h4, 1'b1, 32'd64, 15'd0},
    {4'hF, 1'b0, 32'd8,  15'd1}
  };

  logic          clk = 0;
  logic          rst_n = 0;
  logic          q_reset = 0;
  logic [PW-1:0] depth_m1 = 16'd3;
  logic [AW-1:0] sq_base = 64'h0;
  logic [AW-1:0] cq_base = 64'h100;
  logic          sq_tail_wr = 0;
  logic [PW-1:0] sq_tail_val = '0;
  logic          cq_head_wr = 0;
  logic [PW-1:0] cq_head_val = '0;
  logic          mem_req, mem_we, mem_ack, irq;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;
  logic [PW-1:0] sq_head, cq_tail;

  logic [63:0] mem [1024];
  int total = 0, bad = 0, irq_cnt = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qp_engine #(.AW(AW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .q_reset(q_reset), .depth_m1(depth_m1),
    .sq_base(sq_base), .cq_base(cq_base), .sq_tail_wr(sq_tail_wr), .sq_tail_val(sq_tail_val),
    .cq_head_wr(cq_head_wr), .cq_head_val(cq_head_val), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq(irq), .sq_head(sq_head), .cq_tail(cq_tail)
  );

  // memory model: acknowledge withheld every third cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      cyc <= cyc + 1;
      if (mem_req && !mem_ack && (cyc % 3 != 0)) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[12:3]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[12:3]];
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int slot, input logic [3:0] op, input logic ien, input logic [31:0] len);
    mem[slot*4+0] <= {55'd0, ien, 4'd0, op};
    mem[slot*4+1] <= {len, 32'd0};
    mem[slot*4+2] <= 64'h400;
    mem[slot*4+3] <= 64'h800;
    mem[CQW+slot*2]   <= 64'hDEAD;
    mem[CQW+slot*2+1] <= 64'd0;
  endtask

  task automatic ring_sq(input int tail);
    @(negedge clk);
    sq_tail_wr <= 1'b1; sq_tail_val <= PW'(tail);
    @(negedge clk);
    sq_tail_wr <= 1'b0;
  endtask

  task automatic free_cq(input int head);
    @(negedge clk);
    cq_head_wr <= 1'b1; cq_head_val <= PW'(head);
    @(negedge clk);
    cq_head_wr <= 1'b0;
  endtask

  task automatic wait_cq(input int target);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cq_tail == PW'(target)) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 irq", {63'd0, irq}, 64'd0);
    check("R1 mem_req", {63'd0, mem_req}, 64'd0);
    check("R1 sq_head", {48'd0, sq_head}, 64'd0);
    check("R1 cq_tail", {48'd0, cq_tail}, 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      logic [3:0]  op;
      logic        ien;
      logic [31:0] len;
      logic [14:0] st;
      int slot, nxt, nw, ic;
      {op, ien, len, st} = VEC[v];
      slot = v % 4;
      nxt  = (slot + 1) % 4;
      nw   = (op == 4'h4) ? int'((len + 7) / 8) : 0;
      put_desc(slot, op, ien, len);
      for (int w = 0; w < 9; w++) begin
        mem[SRCW+w] <= 64'hA500_0000_0000_0000 | (64'(v) << 8) | 64'(w + 1);
        mem[DSTW+w] <= 64'd0;
      end
      ic = irq_cnt;
      ring_sq(nxt);
      wait_cq(nxt);
      check("R6 sq_head advance", {48'd0, sq_head}, 64'(nxt));
      check("R7 cq_tail wrap", {48'd0, cq_tail}, 64'(nxt));
      for (int w = 0; w < 9; w++)
        check(w < nw ? "R3 copied word" : "R4 R3 untouched word", mem[DSTW+w],
              w < nw ? (64'hA500_0000_0000_0000 | (64'(v) << 8) | 64'(w + 1)) : 64'd0);
      check("R5 record word0", mem[CQW+slot*2], 64'd0);
      check("R5 R4 record word1", mem[CQW+slot*2+1], {st, 1'b1, 32'd0, 16'(nxt)});
      check("R9 irq count", 64'(irq_cnt - ic), 64'(ien));
      free_cq(nxt);
    end

    // full completion ring: R8
    begin
      int ic;
      for (int w = 0; w < 9; w++) mem[SRCW+w] <= 64'h1234_0000 + 64'(w);
      put_desc(2, 4'h4, 1'b1, 32'd8);
      put_desc(3, 4'h4, 1'b1, 32'd8);
      ring_sq(0);
      wait_cq(0);
      put_desc(0, 4'h4, 1'b1, 32'd8);
      put_desc(1, 4'h4, 1'b1, 32'd8);
      ring_sq(2);
      repeat (80) @(negedge clk);
      check("R8 stalled cq_tail", {48'd0, cq_tail}, 64'd1);
      check("R8 no record while full", mem[CQW+3], 64'd0);
      check("R8 entry fetched", {48'd0, sq_head}, 64'd2);
      ic = irq_cnt;
      free_cq(1);
      wait_cq(2);
      check("R8 resumed cq_tail", {48'd0, cq_tail}, 64'd2);
      check("R8 released record", mem[CQW+3], {15'd0, 1'b1, 32'd0, 16'd2});
      check("R9 single pulse", 64'(irq_cnt - ic), 64'd1);
    end

    // queue reset: R10
    @(negedge clk);
    q_reset <= 1'b1;
    @(negedge clk);
    q_reset <= 1'b0;
    check("R10 sq_head zero", {48'd0, sq_head}, 64'd0);
    check("R10 cq_tail zero", {48'd0, cq_tail}, 64'd0);
    mem[DSTW] <= 64'd0;
    put_desc(0, 4'h4, 1'b0, 32'd8);
    ring_sq(1);
    wait_cq(1);
    check("R10 restart from zero", {48'd0, cq_tail}, 64'd1);
    check("R10 record after reset", mem[CQW+1], {15'd0, 1'b1, 32'd0, 16'd1});
    check("R10 copy after reset", mem[DSTW], 64'h1234_0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule